// File: doc/BRIEF.md
# Leveled Interrupt Router with Claim and Complete

This block gathers level-sensitive interrupt requests from a parameterized set of sources and steers them to a small number of hart contexts. Each context drives one interrupt line. Software programs the block through a 32-bit register port. It sets a priority per source, an enable mask per context and a threshold per context. It then services interrupts by reading a per-context claim register and writing the returned source number back to the same register once it is finished.

Each source has a gateway. When the gateway sees its level asserted, it latches a pending flag, unless the source is already pending or is in flight. A claim read hands the winning source to software and clears its pending flag. The read also marks the source as in flight, which masks it from every context until software completes it. For every context, an arbiter scans the pending sources. It keeps those that are enabled and whose priority is strictly above the context's threshold, and reports the highest-priority one. When priorities are equal, the lowest source number wins. The interrupt line of a context is high whenever its arbiter has a winner.

Top module: `irq_router`

## Requirements
- R1: Source number 0 does not exist. Its priority word reads 0 and ignores writes, and a claim read with no eligible source returns 0.
- R2: The priority of source n (1 to N_SRC) is read and written at byte offset 4*n. Only the low PRIO_W bits are stored, and a read returns them zero-extended.
- R3: The enable mask of context c starts at byte offset 0x2000 + 0x80*c. Source n is controlled by bit (n mod 32) of the 32-bit word at offset 4*(n/32) within that mask. Bits for nonexistent sources read 0.
- R4: The threshold of context c is at 0x200000 + 0x1000*c and keeps PRIO_W bits. The claim/complete register of context c is at 0x200004 + 0x1000*c.
- R5: A source can drive the interrupt line of a context only when three conditions hold: it is pending, it is enabled for that context, and its priority is strictly greater than that context's threshold. A priority of 0 therefore never interrupts.
- R6: Among the eligible sources, a claim returns the one with the highest priority. If several share that priority, it returns the lowest source number.
- R7: A claim read returns the winner and clears its pending flag at the clock edge that accepts the read. The context's interrupt line is low in the following cycle if no other source is eligible.
- R8: A claimed source cannot become pending again, for any context, until its number is written to a claim/complete register. Once that write is done, a level that is still high sets the pending flag again on the next edge.
- R9: A completion write has no effect if its value is a source that is not in flight, or a value outside 1 to N_SRC.
- R10: After reset every priority, enable and threshold register is 0 and every interrupt line is low. A read of an offset that maps to no register returns 0.
- R11: Read data appears on bus_rdata in the cycle after the read request. In cycles without a read, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | N_SRC | Level request of sources 1..N_SRC (bit i-1 is source i) |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| irq_out | output | N_CTX | Interrupt line per context |

## Verification
Threshold tests vary one source's priority against the threshold, above, equal and below, and clear the enable bit. These show strict comparison apart from greater-or-equal, and show that masking works. An arbitration pattern raises four sources at once, with two sharing the top priority and one in the second enable word. Draining them by repeated claims exposes wrong priority order, wrong tie-breaking and wrong enable word decoding, and ends on the empty claim value. A held level combined with wrong, out-of-range and correct completion values separates the in-flight block from the release. A source enabled in both contexts shows that a claim masks it globally.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam logic [31:0] ENABLE_BASE  = 32'h0000_2000;
  localparam int          ENABLE_SHIFT = 7;    // 0x80 bytes per context
  localparam logic [31:0] CTX_BASE     = 32'h0020_0000;
  localparam int          CTX_SHIFT    = 12;   // 0x1000 bytes per context
  localparam logic [11:0] OFF_THRESH   = 12'h000;
  localparam logic [11:0] OFF_CLAIM    = 12'h004;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_ENABLE,
    RG_THRESH,
    RG_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [13:0] ctx;  // context number
    logic [9:0]  idx;  // source number or enable word number
  } reg_sel_t;

  // Enable word that holds source n
  function automatic logic [9:0] src_word(input int n);
    return 10'(n / 32);
  endfunction

  // Bit within that word
  function automatic int src_bit(input int n);
    return n % 32;
  endfunction

  // Map a byte address onto a register selector
  function automatic reg_sel_t decode_addr(input logic [31:0] a,
                                           input logic [31:0] n_src,
                                           input logic [31:0] n_ctx,
                                           input logic [31:0] n_words);
    reg_sel_t    s;
    logic [31:0] off;
    logic [31:0] ctx;
    logic [31:0] word;
    s    = '{kind: RG_NONE, ctx: '0, idx: '0};
    off  = '0;
    ctx  = '0;
    word = '0;
    if (a[1:0] == 2'b00) begin
      if (a < ENABLE_BASE) begin
        if (a < 32'h1000 && {22'b0, a[11:2]} >= 32'd1 && {22'b0, a[11:2]} <= n_src) begin
          s.kind = RG_PRIO;
          s.idx  = a[11:2];
        end
      end else if (a < CTX_BASE) begin
        off  = a - ENABLE_BASE;
        ctx  = off >> ENABLE_SHIFT;
        word = {25'b0, off[ENABLE_SHIFT-1:0]} >> 2;
        if (ctx < n_ctx && word < n_words) begin
          s.kind = RG_ENABLE;
          s.ctx  = ctx[13:0];
          s.idx  = word[9:0];
        end
      end else begin
        off = a - CTX_BASE;
        ctx = off >> CTX_SHIFT;
        if (ctx < n_ctx) begin
          s.ctx = ctx[13:0];
          if (off[CTX_SHIFT-1:0] == OFF_THRESH)     s.kind = RG_THRESH;
          else if (off[CTX_SHIFT-1:0] == OFF_CLAIM) s.kind = RG_CLAIM;
        end
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic claim,
  input  logic complete,
  output logic pending,
  output logic in_flight
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      in_flight <= 1'b0;
    end else if (claim) begin
      pending   <= 1'b0;
      in_flight <= 1'b1;
    end else begin
      if (level && !pending && !in_flight) pending <= 1'b1;
      if (complete) in_flight <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb #(
  parameter int N_SRC  = 40,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC:0]             pend,
  input  logic [N_SRC:0]             en,
  input  logic [N_SRC:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]          thr,
  output logic [ID_W-1:0]            win_id,
  output logic                       irq
);

  logic [PRIO_W-1:0] best_p;

  // Linear scan: strictly-greater replaces, so equal priority keeps the lower number
  always_comb begin
    win_id = '0;
    best_p = thr;
    for (int i = 0; i <= N_SRC; i++) begin
      if (pend[i] && en[i] && prio[i] > best_p) begin
        win_id = ID_W'(i);
        best_p = prio[i];
      end
    end
  end

  assign irq = (win_id != '0);

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_SRC  = 40,
  parameter int N_CTX  = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 26,
  localparam int ID_W    = $clog2(N_SRC + 1),
  localparam int N_WORDS = (N_SRC + 32) / 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_level,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_CTX-1:0]  irq_out
);

  logic [N_SRC:0][PRIO_W-1:0]  prio_q;
  logic [N_CTX-1:0][N_SRC:0]   en_q;
  logic [N_CTX-1:0][PRIO_W-1:0] thr_q;
  logic [N_SRC:0]              pend;
  logic [N_SRC:0]              inflight;
  logic [N_SRC:1]              claim_hit;
  logic [N_SRC:1]              done_hit;
  logic [N_CTX-1:0][ID_W-1:0]  win_id;
  logic [N_CTX-1:0]            ctx_hit;
  reg_sel_t                    sel;
  logic                        rd_fire, wr_fire;
  logic                        claim_fire, done_fire;
  logic [ID_W-1:0]             claim_id;
  logic [31:0]                 rd_val;

  assign sel        = decode_addr(32'(bus_addr), 32'(N_SRC), 32'(N_CTX), 32'(N_WORDS));
  assign rd_fire    = bus_valid && !bus_write;
  assign wr_fire    = bus_valid && bus_write;
  assign claim_fire = rd_fire && sel.kind == RG_CLAIM;
  assign done_fire  = wr_fire && sel.kind == RG_CLAIM;

  generate
    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
      assign ctx_hit[c] = (sel.ctx == 14'(c));
      irq_ctx_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_arb (
        .pend   (pend),
        .en     (en_q[c]),
        .prio   (prio_q),
        .thr    (thr_q[c]),
        .win_id (win_id[c]),
        .irq    (irq_out[c])
      );
    end
  endgenerate

  always_comb begin
    claim_id = '0;
    for (int c = 0; c < N_CTX; c++)
      if (ctx_hit[c]) claim_id = win_id[c];
  end

  assign pend[0]     = 1'b0;
  assign inflight[0] = 1'b0;

  generate
    for (genvar i = 1; i <= N_SRC; i++) begin : g_src
      assign claim_hit[i] = claim_fire && claim_id == ID_W'(i);
      assign done_hit[i]  = done_fire && bus_wdata == 32'(i) && inflight[i];
      irq_src_gate i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (src_level[i-1]),
        .claim     (claim_hit[i]),
        .complete  (done_hit[i]),
        .pending   (pend[i]),
        .in_flight (inflight[i])
      );
    end
  endgenerate

  // Register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr_fire) begin
      case (sel.kind)
        RG_PRIO: begin
          for (int i = 1; i <= N_SRC; i++)
            if (sel.idx == 10'(i)) prio_q[i] <= bus_wdata[PRIO_W-1:0];
        end
        RG_ENABLE: begin
          for (int c = 0; c < N_CTX; c++)
            for (int n = 1; n <= N_SRC; n++)
              if (ctx_hit[c] && sel.idx == src_word(n))
                en_q[c][n] <= bus_wdata[src_bit(n)];
        end
        RG_THRESH: begin
          for (int c = 0; c < N_CTX; c++)
            if (ctx_hit[c]) thr_q[c] <= bus_wdata[PRIO_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    case (sel.kind)
      RG_PRIO: begin
        for (int i = 1; i <= N_SRC; i++)
          if (sel.idx == 10'(i)) rd_val = 32'(prio_q[i]);
      end
      RG_ENABLE: begin
        for (int c = 0; c < N_CTX; c++)
          for (int n = 0; n <= N_SRC; n++)
            if (ctx_hit[c] && sel.idx == src_word(n))
              rd_val[src_bit(n)] = en_q[c][n];
      end
      RG_THRESH: begin
        for (int c = 0; c < N_CTX; c++)
          if (ctx_hit[c]) rd_val = 32'(thr_q[c]);
      end
      RG_CLAIM: rd_val = 32'(claim_id);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_fire ? rd_val : 32'h0;
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_SRC = 40,
  parameter int N_CTX = 2,
  parameter int ID_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CTX-1:0] irq_out,
  input logic [N_SRC:0]   pend,
  input logic [N_SRC:0]   inflight,
  input logic             claim_fire,
  input logic [ID_W-1:0]  claim_id,
  input logic             done_fire,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata
);

  // R11 / R1: the claim value reaches bus_rdata one cycle later, 0 when empty
  p_claim_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    claim_fire |=> bus_rdata == 32'($past(claim_id)));

  generate
    for (genvar i = 1; i <= N_SRC; i++) begin : g_src
      // R7: claimed source leaves pending and enters flight
      p_claim_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire && claim_id == ID_W'(i) |=> inflight[i] && !pend[i]);
      // R8: no re-pend while in flight
      p_flight_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inflight[i] |=> !pend[i]);
      // R9: release only through a completion naming this source
      p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inflight[i]) |-> $past(done_fire) && $past(bus_wdata) == 32'(i));
    end
  endgenerate

  // R5: with nothing pending no line can be high
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend == '0 |-> irq_out == '0);

endmodule

bind irq_router irq_router_chk #(.N_SRC(N_SRC), .N_CTX(N_CTX), .ID_W(ID_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_out    (irq_out),
  .pend       (pend),
  .inflight   (inflight),
  .claim_fire (claim_fire),
  .claim_id   (claim_id),
  .done_fire  (done_fire),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata)
);

// File: tb/test_irq_router.sv
module test_irq_router;

  localparam int CLK_PERIOD = 10;
  localparam int N_SRC  = 40;
  localparam int N_CTX  = 2;
  localparam int ADDR_W = 26;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_SRC-1:0]  src_level = '0;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [N_CTX-1:0]  irq_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router #(.N_SRC(N_SRC), .N_CTX(N_CTX), .PRIO_W(3), .ADDR_W(ADDR_W)) i_irq_router (
    .clk(clk), .rst_n(rst_n), .src_level(src_level),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [31:0] a_prio(int n);       return 32'(4 * n); endfunction
  function automatic logic [31:0] a_en(int c, int w);  return 32'('h2000 + 'h80 * c + 4 * w); endfunction
  function automatic logic [31:0] a_thr(int c);        return 32'('h200000 + 'h1000 * c); endfunction
  function automatic logic [31:0] a_claim(int c);      return 32'('h200004 + 'h1000 * c); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    src_level = '0;
    bus_valid = 1'b0;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a[ADDR_W-1:0];
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    check("R10 irq after reset", 32'(irq_out), 32'h0);
    rd(a_prio(1), d);      check("R10 prio reset", d, 32'h0);
    rd(a_en(1, 1), d);     check("R10 enable reset", d, 32'h0);
    rd(a_thr(1), d);       check("R10 thresh reset", d, 32'h0);
    rd(a_claim(0), d);     check("R1 empty claim", d, 32'h0);
    rd(32'h1000, d);       check("R10 unmapped gap", d, 32'h0);
    rd(a_en(2, 0), d);     check("R10 missing context", d, 32'h0);
    tick(1);
    check("R11 rdata idle", bus_rdata, 32'h0);
  endtask

  task automatic t_registers();
    logic [31:0] d;
    do_reset();
    wr(a_prio(5), 32'h6);         rd(a_prio(5), d);   check("R2 prio readback", d, 32'h6);
    wr(a_prio(N_SRC), 32'hF);     rd(a_prio(N_SRC), d); check("R2 prio width", d, 32'h7);
    wr(a_prio(0), 32'h5);         rd(a_prio(0), d);   check("R1 prio of source 0", d, 32'h0);
    wr(a_en(0, 0), 32'hFFFF_FFFF); rd(a_en(0, 0), d); check("R3 enable word0", d, 32'hFFFF_FFFE);
    wr(a_en(1, 1), 32'hFFFF_FFFF); rd(a_en(1, 1), d); check("R3 enable word1", d, 32'h0000_01FF);
    rd(a_en(0, 1), d);            check("R3 context separation", d, 32'h0);
    wr(a_thr(1), 32'h5);          rd(a_thr(1), d);    check("R4 thresh readback", d, 32'h5);
    rd(a_thr(0), d);              check("R4 thresh other context", d, 32'h0);
  endtask

  task automatic t_threshold();
    do_reset();
    wr(a_prio(3), 32'h2);
    wr(a_en(0, 0), 32'h1 << 3);
    wr(a_thr(0), 32'h2);
    src_level[2] = 1'b1;
    tick(2);
    check("R5 equal to threshold", 32'(irq_out), 32'h0);
    wr(a_thr(0), 32'h1);
    check("R5 above threshold", 32'(irq_out), 32'h1);
    wr(a_thr(0), 32'h0);
    wr(a_prio(3), 32'h0);
    check("R5 priority zero", 32'(irq_out), 32'h0);
    wr(a_prio(3), 32'h4);
    check("R5 re-raised", 32'(irq_out), 32'h1);
    wr(a_en(0, 0), 32'h0);
    check("R5 disabled", 32'(irq_out), 32'h0);
  endtask

  task automatic t_arbitration();
    logic [31:0] d;
    do_reset();
    wr(a_prio(4), 32'h3);
    wr(a_prio(9), 32'h5);
    wr(a_prio(12), 32'h5);
    wr(a_prio(35), 32'h1);
    wr(a_en(0, 0), (32'h1 << 4) | (32'h1 << 9) | (32'h1 << 12));
    wr(a_en(0, 1), 32'h1 << 3);   // source 35
    src_level[3] = 1'b1; src_level[8] = 1'b1; src_level[11] = 1'b1; src_level[34] = 1'b1;
    tick(2);
    check("R6 line up", 32'(irq_out), 32'h1);
    rd(a_claim(0), d); check("R6 tie lowest id", d, 32'd9);
    rd(a_claim(0), d); check("R6 second of tie", d, 32'd12);
    rd(a_claim(0), d); check("R6 next priority", d, 32'd4);
    rd(a_claim(0), d); check("R3 word1 source", d, 32'd35);
    check("R7 line drops after last claim", 32'(irq_out), 32'h0);
    rd(a_claim(0), d); check("R1 drained claim", d, 32'h0);
  endtask

  task automatic t_claim_complete();
    logic [31:0] d;
    do_reset();
    wr(a_prio(2), 32'h1);
    wr(a_prio(6), 32'h2);
    wr(a_en(0, 0), (32'h1 << 2) | (32'h1 << 6));
    wr(a_en(1, 0), 32'h1 << 6);
    src_level[1] = 1'b1;
    tick(2);
    rd(a_claim(0), d); check("R7 claim id", d, 32'd2);
    check("R7 line low after claim", 32'(irq_out), 32'h0);
    tick(3);
    check("R8 held level blocked", 32'(irq_out), 32'h0);
    wr(a_claim(0), 32'd7);
    tick(2);
    check("R9 unclaimed id ignored", 32'(irq_out), 32'h0);
    wr(a_claim(0), 32'h1000_0002);
    tick(2);
    check("R9 out of range ignored", 32'(irq_out), 32'h0);
    wr(a_claim(0), 32'd2);
    tick(1);
    check("R8 re-pend after completion", 32'(irq_out), 32'h1);
    rd(a_claim(0), d); check("R8 second claim", d, 32'd2);
    src_level[1] = 1'b0;
    wr(a_claim(0), 32'd2);
    tick(2);
    check("R8 no re-pend when level low", 32'(irq_out), 32'h0);
    src_level[5] = 1'b1;
    tick(2);
    check("R5 shared source both lines", 32'(irq_out), 32'h3);
    rd(a_claim(1), d); check("R7 claim from context 1", d, 32'd6);
    check("R8 claim masks all contexts", 32'(irq_out), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_registers();
    t_threshold();
    t_arbitration();
    t_claim_complete();
    tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule